// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns single read and write requests into closed-page SDRAM command sequences, and turns a refresh request into a precharge-all followed by REFRESH. Between commands it inserts wait states. Their number comes from a 2-bit bank-cycle code and a 3-bit read-latency code. Four copies of these codes are supplied, one for each memory region. The region bits of the request address pick which copy applies. That copy is captured when the request is accepted and holds for the whole access.

One bank-cycle code sets both the delay from activate to column command and the delay from precharge back to idle. The refresh recovery time is four times that code. The external wait line plays no part in any of this timing.

A requester presents an address, a direction and write data, and holds them until the block signals ready. The sequencer accepts a request only when it is idle. A refresh request is latched and is served before any new access.

Top module: `sdram_cmd_seq`

## Requirements
- R1: An accepted access drives ACTIVATE with the bank and row, then READ or WRITE with the column (address bit 10 low), then PRECHARGE of that bank (address 0), then returns to idle. The request address is {region[23:22], bank[21:20], row[19:8], col[7:0]}. ACTIVATE appears in the cycle after the one in which `req_valid` and `req_ready` are both high.
- R2: Between ACTIVATE and READ/WRITE there are exactly N NOP cycles. N is the selected region's bank-cycle code: 01→1, 10→2, 11→3, and the reserved 00→1.
- R3: PRECHARGE is followed by N NOP cycles, using the same N as R2. `req_ready` is high again in the next cycle.
- R4: The read latency is 2 for code 010 and 3 for every other code. `rd_valid` is high for one cycle, exactly latency cycles after the READ cycle, and `rd_data` then equals `sd_dq_in`. After a READ, PRECHARGE follows in the cycle after `rd_valid`. After a WRITE, PRECHARGE follows after one NOP.
- R5: A refresh drives PRECHARGE with address bit 10 high and bank 0, then M NOP cycles, then REFRESH, then 4·M NOP cycles, then idle. M is the largest decoded bank-cycle wait among the four regions.
- R6: `req_ready` is low whenever `ref_req` is high or a refresh is pending. A refresh requested during an access starts in the first idle cycle after that access. If a refresh and a request arrive together, the refresh runs first.
- R7: Region i takes its codes from `cfg_bcw[2i+1:2i]` and `cfg_lat[3i+2:3i]`. The region field of the accepted address selects which region applies.
- R8: The command pins {cs_n, ras_n, cas_n, we_n} use these encodings: deselect 1111 (idle), NOP 0111 (every wait cycle), ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001. In idle and wait cycles, `sd_ba` and `sd_a` are 0.
- R9: `sd_dq_oe` is high only in the WRITE cycle, and `sd_dq_out` then carries the accepted write data.
- R10: `ext_wait` has no effect on any command, timing or output.
- R11: Under reset the pins show deselect, `req_ready` is high, and `sd_dq_oe` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | {region, bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request is accepted in this cycle if valid |
| ref_req | input | 1 | Refresh request pulse |
| ext_wait | input | 1 | External wait line, ignored |
| cfg_bcw | input | 8 | Four 2-bit bank-cycle codes |
| cfg_lat | input | 12 | Four 3-bit read-latency codes |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row/column address |
| sd_dq_out | output | 16 | Write data to the memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Read data from the memory |
| rd_data | output | 16 | Read data to the requester |
| rd_valid | output | 1 | Read data strobe |

## Verification
The assertions are checked in every cycle. They cover:
- the activate-to-column spacing against the captured wait code;
- the read strobe's distance from READ against the captured latency;
- NOP on the pins whenever the sequencer is waiting;
- silence on the bus throughout refresh recovery;
- readiness being blocked by a refresh request.

Other properties can only be shown by the bench's scenarios, whose reference model predicts every pin in every cycle. These are:
- the decoding of the reserved codes;
- the choice of the largest wait for refresh;
- the ordering between a refresh and an access that arrive together or overlap;
- the correct region being selected;
- the exact data values carried on the bus.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  localparam int WAIT_CNT_W = 4;  // holds up to 4 * 3 refresh waits

  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACT, ST_TRCD, ST_COL, ST_DATA,
    ST_PRE, ST_TRP, ST_PALL, ST_TPALL, ST_REF, ST_TRFC
  } seq_st_e;

  // bank-cycle code to wait count; reserved 00 behaves as 1
  function automatic logic [1:0] bank_wait(input logic [1:0] code);
    return (code == 2'b00) ? 2'd1 : code;
  endfunction

  // latency code to cycles; anything but 010 falls back to 3
  function automatic logic [1:0] cas_lat(input logic [2:0] code);
    return (code == 3'b010) ? 2'd2 : 2'd3;
  endfunction

  // refresh recovery is four times the decoded bank-cycle wait
  function automatic logic [WAIT_CNT_W-1:0] refresh_wait(input logic [1:0] w);
    return {w, 2'b00};
  endfunction

endpackage

// File: rtl/sdseq_cfg.sv
module sdseq_cfg
  import sdseq_pkg::*;
#(
  parameter int RSEL_W = 2,
  parameter int NREG   = 1 << RSEL_W
) (
  input  logic [2*NREG-1:0] cfg_bcw,
  input  logic [3*NREG-1:0] cfg_lat,
  input  logic [RSEL_W-1:0] sel,
  output logic [1:0]        sel_wait,
  output logic [1:0]        sel_lat,
  output logic [1:0]        max_wait
);

  logic [1:0] w_dec [NREG];
  logic [1:0] l_dec [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign w_dec[g] = bank_wait(cfg_bcw[2*g +: 2]);
    assign l_dec[g] = cas_lat(cfg_lat[3*g +: 3]);
  end

  assign sel_wait = w_dec[sel];
  assign sel_lat  = l_dec[sel];

  always_comb begin
    max_wait = w_dec[0];
    for (int i = 1; i < NREG; i++) begin
      if (w_dec[i] > max_wait) max_wait = w_dec[i];
    end
  end

endmodule

// File: rtl/sdseq_wait_cnt.sv
module sdseq_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BA_W   = 2,
  parameter int RSEL_W = 2,
  parameter int DQ_W   = 16,
  parameter int AP_BIT = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [RSEL_W+BA_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]                   req_wdata,
  output logic                              req_ready,
  input  logic                              ref_req,
  input  logic                              ext_wait,
  input  logic [2*(1<<RSEL_W)-1:0]          cfg_bcw,
  input  logic [3*(1<<RSEL_W)-1:0]          cfg_lat,
  output logic                              sd_cs_n,
  output logic                              sd_ras_n,
  output logic                              sd_cas_n,
  output logic                              sd_we_n,
  output logic [BA_W-1:0]                   sd_ba,
  output logic [ROW_W-1:0]                  sd_a,
  output logic [DQ_W-1:0]                   sd_dq_out,
  output logic                              sd_dq_oe,
  input  logic [DQ_W-1:0]                   sd_dq_in,
  output logic [DQ_W-1:0]                   rd_data,
  output logic                              rd_valid
);

  localparam int NREG    = 1 << RSEL_W;
  localparam int ROW_LSB = COL_W;
  localparam int BA_LSB  = COL_W + ROW_W;
  localparam int RS_LSB  = COL_W + ROW_W + BA_W;

  seq_st_e state, state_nx;
  sd_cmd_e cmd;

  logic              q_write;
  logic [BA_W-1:0]   q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;
  logic [DQ_W-1:0]   q_wdata;
  logic [1:0]        q_wait, q_lat, q_rwait;
  logic              ref_pend;

  logic [1:0] sel_wait, sel_lat, max_wait;
  logic                  cnt_load, cnt_last;
  logic [WAIT_CNT_W-1:0] cnt_val;

  // named internal events, observed by the bound checker
  logic accept, start_ref, in_wait;

  sdseq_cfg #(.RSEL_W(RSEL_W), .NREG(NREG)) u_cfg (
    .cfg_bcw  (cfg_bcw),
    .cfg_lat  (cfg_lat),
    .sel      (req_addr[RS_LSB +: RSEL_W]),
    .sel_wait (sel_wait),
    .sel_lat  (sel_lat),
    .max_wait (max_wait)
  );

  sdseq_wait_cnt #(.CNT_W(WAIT_CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  assign start_ref = (state == ST_IDLE) && (ref_pend || ref_req);
  assign req_ready = (state == ST_IDLE) && !ref_pend && !ref_req;
  assign accept    = req_valid && req_ready;
  assign in_wait   = state inside {ST_TRCD, ST_DATA, ST_TRP, ST_TPALL, ST_TRFC};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ref_pend <= 1'b0;
      q_write  <= 1'b0;
      q_bank   <= '0;
      q_row    <= '0;
      q_col    <= '0;
      q_wdata  <= '0;
      q_wait   <= 2'd1;
      q_lat    <= 2'd3;
      q_rwait  <= 2'd1;
    end else begin
      state <= state_nx;
      if (start_ref)    ref_pend <= 1'b0;
      else if (ref_req) ref_pend <= 1'b1;
      if (accept) begin
        q_write <= req_write;
        q_bank  <= req_addr[BA_LSB +: BA_W];
        q_row   <= req_addr[ROW_LSB +: ROW_W];
        q_col   <= req_addr[COL_W-1:0];
        q_wdata <= req_wdata;
        q_wait  <= sel_wait;
        q_lat   <= sel_lat;
      end
      if (start_ref) q_rwait <= max_wait;
    end
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_ref) state_nx = ST_PALL;
                else if (accept) state_nx = ST_ACT;
      ST_ACT:   state_nx = ST_TRCD;
      ST_TRCD:  if (cnt_last) state_nx = ST_COL;
      ST_COL:   state_nx = ST_DATA;
      ST_DATA:  if (cnt_last) state_nx = ST_PRE;
      ST_PRE:   state_nx = ST_TRP;
      ST_TRP:   if (cnt_last) state_nx = ST_IDLE;
      ST_PALL:  state_nx = ST_TPALL;
      ST_TPALL: if (cnt_last) state_nx = ST_REF;
      ST_REF:   state_nx = ST_TRFC;
      ST_TRFC:  if (cnt_last) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  // each command state loads the length of the wait that follows it
  always_comb begin
    cnt_load = 1'b1;
    cnt_val  = '0;
    case (state)
      ST_ACT:  cnt_val = WAIT_CNT_W'(q_wait);
      ST_COL:  cnt_val = q_write ? WAIT_CNT_W'(1) : WAIT_CNT_W'(q_lat);
      ST_PRE:  cnt_val = WAIT_CNT_W'(q_wait);
      ST_PALL: cnt_val = WAIT_CNT_W'(q_rwait);
      ST_REF:  cnt_val = refresh_wait(q_rwait);
      default: cnt_load = 1'b0;
    endcase
  end

  always_comb begin
    cmd   = CMD_NOP;
    sd_ba = '0;
    sd_a  = '0;
    case (state)
      ST_IDLE: cmd = CMD_DESEL;
      ST_ACT: begin
        cmd   = CMD_ACT;
        sd_ba = q_bank;
        sd_a  = q_row;
      end
      ST_COL: begin
        cmd   = q_write ? CMD_WR : CMD_RD;
        sd_ba = q_bank;
        sd_a  = ROW_W'(q_col);
      end
      ST_PRE: begin
        cmd   = CMD_PRE;
        sd_ba = q_bank;
      end
      ST_PALL: begin
        cmd          = CMD_PRE;
        sd_a[AP_BIT] = 1'b1;
      end
      ST_REF:  cmd = CMD_REF;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  assign sd_dq_oe  = (state == ST_COL) && q_write;
  assign sd_dq_out = sd_dq_oe ? q_wdata : '0;
  assign rd_valid  = (state == ST_DATA) && cnt_last && !q_write;
  assign rd_data   = sd_dq_in;

endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       req_ready,
  input logic       ref_req,
  input logic       ext_wait,
  input logic       rd_valid,
  input logic       dq_oe,
  input logic       in_wait,
  input logic [1:0] acc_wait,
  input logic [1:0] acc_lat,
  input logic [1:0] ref_wait
);

  logic [3:0] pins;
  logic       is_act, is_rd, is_wr, is_ref, is_nop;
  logic [3:0] quiet_cnt;

  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_act = (pins == 4'b0011);
  assign is_rd  = (pins == 4'b0101);
  assign is_wr  = (pins == 4'b0100);
  assign is_ref = (pins == 4'b0001);
  assign is_nop = (pins == 4'b0111);

  // cycles of refresh recovery still owed, counted from the REFRESH pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_cnt <= '0;
    else if (is_ref)           quiet_cnt <= {ref_wait, 2'b00};
    else if (quiet_cnt != '0)  quiet_cnt <= quiet_cnt - 1'b1;
  end

  a_r2_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> ((acc_wait == 2'd1 && $past(is_act, 2)) ||
                          (acc_wait == 2'd2 && $past(is_act, 3)) ||
                          (acc_wait == 2'd3 && $past(is_act, 4))));

  a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((acc_lat == 2'd2 && $past(is_rd, 2)) ||
                  (acc_lat == 2'd3 && $past(is_rd, 3))));

  a_r8_wait_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> is_nop);

  a_r8_ready_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pins == 4'b1111));

  a_r5_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_cnt != '0) |-> is_nop);

  a_r6_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);

  a_r9_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> is_wr);

  a_r10_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wait && is_act) |=> is_nop);

endmodule

bind sdram_cmd_seq sdseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (sd_cs_n),
  .ras_n     (sd_ras_n),
  .cas_n     (sd_cas_n),
  .we_n      (sd_we_n),
  .req_ready (req_ready),
  .ref_req   (ref_req),
  .ext_wait  (ext_wait),
  .rd_valid  (rd_valid),
  .dq_oe     (sd_dq_oe),
  .in_wait   (in_wait),
  .acc_wait  (q_wait),
  .acc_lat   (q_lat),
  .ref_wait  (q_rwait)
);

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;

  localparam logic [3:0] P_DESEL = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_PRE = 4'b0010,
                         P_REF = 4'b0001;

  typedef struct packed {
    logic        rdy;
    logic        rv;
    logic        oe;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] a;
    logic [15:0] dq;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0, ext_wait = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rd_pat = '0;
  logic [1:0]  cb [4];
  logic [2:0]  cl [4];
  logic [7:0]  cfg_bcw;
  logic [11:0] cfg_lat;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, rd_valid;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [15:0] sd_dq_out, rd_data;

  ent_t  exp_q [$];
  string tag_q [$];
  int    n_vec = 0, n_bad = 0, cyc = 0;
  logic  chk_en = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign cfg_bcw = {cb[3], cb[2], cb[1], cb[0]};
  assign cfg_lat = {cl[3], cl[2], cl[1], cl[0]};

  sdram_cmd_seq i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ref_req(ref_req), .ext_wait(ext_wait), .cfg_bcw(cfg_bcw), .cfg_lat(cfg_lat),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(rd_pat), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic int wait_of(input logic [1:0] c);
    return (c == 2'b00) ? 1 : int'(c);
  endfunction

  function automatic int lat_of(input logic [2:0] c);
    return (c == 3'b010) ? 2 : 3;
  endfunction

  function automatic int ref_m();
    int m = 0;
    for (int i = 0; i < 4; i++) if (wait_of(cb[i]) > m) m = wait_of(cb[i]);
    return m;
  endfunction

  task automatic push(input logic rdy, input logic rv, input logic oe,
                      input logic [3:0] cmd, input logic [1:0] ba,
                      input logic [11:0] a, input logic [15:0] dq, input string t);
    ent_t e;
    e = '{rdy: rdy, rv: rv, oe: oe, cmd: cmd, ba: ba, a: a, dq: dq};
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // closed-page access, starting with the idle cycle that accepts it
  task automatic push_access(input logic wr, input logic [1:0] rg, input logic [1:0] bk,
                             input logic [11:0] row, input logic [7:0] col,
                             input logic [15:0] d, input string xt);
    int w = wait_of(cb[rg]);
    int c = lat_of(cl[rg]);
    push(1, 0, 0, P_DESEL, 0, 0, 0, "R1");
    push(0, 0, 0, P_ACT, bk, row, 0, "R1");
    for (int i = 0; i < w; i++) push(0, 0, 0, P_NOP, 0, 0, 0, {"R2", xt});
    push(0, 0, wr, wr ? P_WR : P_RD, bk, {4'h0, col}, wr ? d : 16'h0, wr ? "R9" : "R1");
    if (wr) push(0, 0, 0, P_NOP, 0, 0, 0, "R9");
    else for (int i = 0; i < c; i++)
      push(0, i == c - 1, 0, P_NOP, 0, 0, (i == c - 1) ? d : 16'h0, {"R4", xt});
    push(0, 0, 0, P_PRE, bk, 0, 0, "R1");
    for (int i = 0; i < w; i++) push(0, 0, 0, P_NOP, 0, 0, 0, {"R3", xt});
  endtask

  // refresh, starting with the idle cycle in which it is taken up
  task automatic push_refresh();
    int m = ref_m();
    push(0, 0, 0, P_DESEL, 0, 0, 0, "R6");
    push(0, 0, 0, P_PRE, 0, 12'h400, 0, "R5");
    for (int i = 0; i < m; i++) push(0, 0, 0, P_NOP, 0, 0, 0, "R5");
    push(0, 0, 0, P_REF, 0, 0, 0, "R5");
    for (int i = 0; i < 4 * m; i++) push(0, 0, 0, P_NOP, 0, 0, 0, "R5");
  endtask

  task automatic wait_idle();
    @(posedge clk); #1;
    while (exp_q.size() != 0) begin @(posedge clk); #1; end
  endtask

  task automatic access(input logic wr, input logic [1:0] rg, input logic [1:0] bk,
                        input logic [11:0] row, input logic [7:0] col,
                        input logic [15:0] d, input string xt);
    wait_idle();
    push_access(wr, rg, bk, row, col, d, xt);
    req_write = wr; req_addr = {rg, bk, row, col}; req_wdata = d; rd_pat = d;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; req_wdata = 16'hdead;
  endtask

  task automatic refresh();
    wait_idle();
    push_refresh();
    ref_req = 1'b1;
    @(posedge clk); #1;
    ref_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // reference comparison, away from the active edge
  always @(negedge clk) begin : mon
    ent_t  e, g;
    string t;
    if (chk_en) begin
      if (exp_q.size() == 0) begin
        e = '{rdy: 1'b1, rv: 1'b0, oe: 1'b0, cmd: P_DESEL, ba: 2'b0, a: 12'h0, dq: 16'h0};
        t = "R8";
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end
      g = '{rdy: req_ready, rv: rd_valid, oe: sd_dq_oe,
            cmd: {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, ba: sd_ba, a: sd_a,
            dq: sd_dq_oe ? sd_dq_out : rd_data};
      if (!(e.oe || e.rv)) g.dq = e.dq;
      n_vec++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s t=%0t: got rdy=%b rv=%b oe=%b cmd=%b ba=%0d a=%h dq=%h, exp rdy=%b rv=%b oe=%b cmd=%b ba=%0d a=%h dq=%h",
                 t, $time, g.rdy, g.rv, g.oe, g.cmd, g.ba, g.a, g.dq,
                 e.rdy, e.rv, e.oe, e.cmd, e.ba, e.a, e.dq);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R1 watchdog: got %0d cycles, exp under 20000", cyc);
      finish_run();
    end
  end

  initial begin
    // R7: distinct codes per region; regions 2 and 3 use reserved codes
    cb[0] = 2'b01; cl[0] = 3'b010;
    cb[1] = 2'b10; cl[1] = 3'b011;
    cb[2] = 2'b11; cl[2] = 3'b000;
    cb[3] = 2'b00; cl[3] = 3'b111;
    repeat (3) @(negedge clk);
    // R11: state held under reset
    n_vec++;
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} !== P_DESEL || req_ready !== 1'b1 ||
        sd_dq_oe !== 1'b0 || rd_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: got cmd=%b rdy=%b oe=%b rv=%b, exp cmd=1111 rdy=1 oe=0 rv=0",
               {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, req_ready, sd_dq_oe, rd_valid);
    end
    @(posedge clk); #1;
    rst_n  = 1'b1;
    chk_en = 1'b1;

    access(1'b1, 2'd0, 2'd1, 12'h123, 8'h45, 16'ha5a5, "");      // R1 R2 R9
    access(1'b0, 2'd0, 2'd2, 12'h0ff, 8'h10, 16'h1234, "");      // R4 latency 2
    access(1'b0, 2'd1, 2'd3, 12'h800, 8'hff, 16'hbeef, " R7");   // R7 wait 2, latency 3
    access(1'b1, 2'd2, 2'd0, 12'hfff, 8'h01, 16'h5a5a, " R7");   // R2 wait 3
    access(1'b0, 2'd2, 2'd1, 12'h00a, 8'h80, 16'hc001, " R7");   // R4 reserved latency
    ext_wait = 1'b1;                                              // R10
    access(1'b0, 2'd3, 2'd2, 12'h3c3, 8'h3c, 16'h0f0f, " R10");  // reserved wait 00
    access(1'b1, 2'd1, 2'd1, 12'h555, 8'haa, 16'hffff, " R10");
    ext_wait = 1'b0;
    refresh();                                                    // R5 max wait 3

    // R6: refresh requested during an access runs right after it
    access(1'b0, 2'd0, 2'd0, 12'h111, 8'h22, 16'h7777, "");
    push_refresh();
    ref_req = 1'b1;
    @(posedge clk); #1;
    ref_req = 1'b0;

    // R6: simultaneous refresh and request, refresh first
    wait_idle();
    begin
      int len;
      len = 1 + 1 + ref_m() + 1 + 4 * ref_m();
      push_refresh();
      push_access(1'b1, 2'd1, 2'd2, 12'h0aa, 8'h55, 16'h3333, " R6");
      req_write = 1'b1; req_addr = {2'd1, 2'd2, 12'h0aa, 8'h55}; req_wdata = 16'h3333;
      req_valid = 1'b1; ref_req = 1'b1;
      @(posedge clk); #1;
      ref_req = 1'b0;
      repeat (len) @(posedge clk);
      #1;
      req_valid = 1'b0;
    end

    // R5: smaller largest wait changes refresh spacing
    wait_idle();
    cb[0] = 2'b01; cb[1] = 2'b00; cb[2] = 2'b01; cb[3] = 2'b01;
    refresh();
    wait_idle();
    cb[2] = 2'b10;
    refresh();
    access(1'b0, 2'd2, 2'd3, 12'h246, 8'h99, 16'h8421, " R7");

    wait_idle();
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule